// File: doc/BRIEF.md
# Edge-Framed Oversampling UART Receiver

This block recovers asynchronous serial characters with a fixed-length sampling engine instead of a mid-bit voting receiver. The serial line is sampled on a divided tick at roughly twice the bit rate. A falling edge on the line itself, seen from one tick to the next, acts as an active-low frame sync and opens a word of a known number of samples. When the word is complete, the character is rebuilt by keeping every other sample, and it is written into a small receive FIFO.

The tick period is set at run time, so software can choose a divider that runs the sampling a few percent faster than twice the nominal bit rate. That margin absorbs the baud tolerance of the far end. Parity, framing errors and break conditions are not examined. A host reads characters with a one-cycle pop strobe and watches the not-empty flag and the sticky overflow flag.

Top module: `rxo_uart_rx`

## Requirements
- R1: After synchronous reset, not_empty, overflow and rd_valid are all 0.
- R2: When rx_en is high, a sample tick occurs every samp_div+1 clock cycles. A word opens on the tick where the synchronised line reads 0 and the previous tick read 1. Samples are numbered from 0, starting at the next tick. Data bit k is sample 2k+1, and the character is assembled LSB first.
- R3: cfg_len selects the data length: codes 0, 1, 2 and 3 give 5, 6, 7 and 8 bits. rd_data bits at and above the data length read 0.
- R4: cfg_two_stop=1 selects two stop bits and cfg_two_stop=0 selects one. A word spans 2*(data bits + stop bits + 1) - 1 samples, which is 21 for 8 data bits with two stop bits. The configuration is captured when the word opens.
- R5: A line that is already low when sampling starts does not open a word. The line must first be seen high.
- R6: Falling edges inside an open word, such as those within the data bits, do not open a further word, so each character produces exactly one FIFO entry.
- R7: The FIFO returns characters in arrival order. A pop while not_empty=1 gives rd_valid=1 with the oldest character on the next cycle. A pop while the FIFO is empty gives rd_valid=0. not_empty is 1 exactly while at least one character is stored.
- R8: If a character completes while the 8-entry FIFO is full and no pop occurs in that cycle, the character is dropped, the stored entries are kept, and overflow becomes 1.
- R9: overflow stays 1 until a cycle with ovf_clr=1. It is cleared on the next cycle, unless a new overflow occurs in that same cycle.
- R10: Lowering rx_en aborts any open word without writing it to the FIFO, and leaves the FIFO contents intact.
- R11: The character is recovered correctly at more than one samp_div setting when the bit period is 2*(samp_div+1) clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_en | input | 1 | Receiver enable; low aborts sampling |
| rx_serial | input | 1 | Asynchronous serial line, idle high |
| cfg_len | input | 2 | Data length code (5 + code bits) |
| cfg_two_stop | input | 1 | 1 selects two stop bits |
| samp_div | input | 16 | Sample tick period minus one, in clocks |
| pop | input | 1 | Remove the oldest FIFO entry |
| ovf_clr | input | 1 | Write-one-to-clear for overflow |
| rd_data | output | 8 | Popped character, valid with rd_valid |
| rd_valid | output | 1 | rd_data updated by the previous pop |
| not_empty | output | 1 | At least one character is stored |
| overflow | output | 1 | Sticky: a character was dropped |

## Verification
A slip in the sample index or the captured length shows up as shifted or wrong bits in the first popped character. That character is visible about one bit time after the stop bit. A framing state that fails to return to idle, or that re-opens on an in-word edge, shows as missing or extra FIFO entries. This is caught by not_empty right after the single expected pop. Errors in FIFO pointers or counts show during the fill-to-overflow run as reordered data, a missing overflow flag, or a flag that does not stick.

// File: rtl/rxo_pkg.sv
package rxo_pkg;
  localparam int MIN_BITS = 5;
  localparam int LEN_W    = 2;

  typedef enum logic {ST_IDLE, ST_WORD} rxo_state_e;

  function automatic int data_bits(input logic [LEN_W-1:0] len);
    return MIN_BITS + int'(len);
  endfunction

  // index of the final sample in a word: 2*(data + stop + 1) - 2
  function automatic int word_last(input logic [LEN_W-1:0] len, input logic two_stop);
    return 2 * (data_bits(len) + 1 + int'(two_stop) + 1) - 2;
  endfunction
endpackage

// File: rtl/rxo_tick_gen.sv
module rxo_tick_gen #(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);
  logic [DIV_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      tick  <= 1'b0;
    end else if (!en) begin
      cnt_q <= div;
      tick  <= 1'b0;
    end else if (cnt_q == '0) begin
      cnt_q <= div;
      tick  <= 1'b1;
    end else begin
      cnt_q <= cnt_q - 1'b1;
      tick  <= 1'b0;
    end
  end
endmodule

// File: rtl/rxo_word_sampler.sv
module rxo_word_sampler
  import rxo_pkg::*;
#(
  parameter int MAX_BITS = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                en,
  input  logic                tick,
  input  logic                line_s,
  input  logic [LEN_W-1:0]    cfg_len,
  input  logic                cfg_two_stop,
  output logic                push,
  output logic [MAX_BITS-1:0] push_data
);
  localparam int SAMP_W = 2 * (MAX_BITS + 3) - 1;
  localparam int IDX_W  = $clog2(SAMP_W);

  rxo_state_e         state_q;
  logic               prev_q;
  logic [IDX_W-1:0]   idx_q;
  logic [IDX_W-1:0]   last_q;
  logic [LEN_W-1:0]   len_q;
  logic [SAMP_W-1:0]  samp_q;
  logic [MAX_BITS-1:0] extract;

  // keep sample 2k+1 as data bit k; bits beyond the length read zero
  always_comb begin
    extract = '0;
    for (int k = 0; k < MAX_BITS; k++) begin
      if (k < data_bits(len_q)) extract[k] = samp_q[2*k+1];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= ST_IDLE;
      prev_q    <= 1'b0;
      idx_q     <= '0;
      last_q    <= '0;
      len_q     <= '0;
      samp_q    <= '0;
      push      <= 1'b0;
      push_data <= '0;
    end else begin
      push <= 1'b0;
      if (!en) begin
        state_q <= ST_IDLE;
        idx_q   <= '0;
        prev_q  <= 1'b0;
      end else if (tick) begin
        prev_q <= line_s;
        case (state_q)
          ST_IDLE: begin
            if (prev_q && !line_s) begin
              state_q <= ST_WORD;
              idx_q   <= '0;
              len_q   <= cfg_len;
              last_q  <= IDX_W'(word_last(cfg_len, cfg_two_stop));
            end
          end
          ST_WORD: begin
            samp_q[idx_q] <= line_s;
            if (idx_q == last_q) begin
              state_q   <= ST_IDLE;
              push      <= 1'b1;
              push_data <= extract;
            end else begin
              idx_q <= idx_q + 1'b1;
            end
          end
          default: state_q <= ST_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/rxo_fifo.sv
module rxo_fifo #(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              push,
  input  logic [DATA_W-1:0] wdata,
  input  logic              pop,
  input  logic              ovf_clr,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_valid,
  output logic              not_empty,
  output logic              overflow,
  output logic              full
);
  localparam int AW    = $clog2(DEPTH);
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [DATA_W-1:0] mem [DEPTH];
  logic [AW-1:0]     wp_q, rp_q;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic              do_rd, do_wr;

  assign full  = (cnt_q == CNT_W'(DEPTH));
  assign do_rd = pop && (cnt_q != '0);
  assign do_wr = push && (!full || do_rd);

  always_comb begin
    cnt_d = cnt_q;
    if (do_wr && !do_rd) cnt_d = cnt_q + 1'b1;
    if (do_rd && !do_wr) cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk) begin
    if (do_wr) mem[wp_q] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (rst)        rd_data <= '0;
    else if (do_rd) rd_data <= mem[rp_q];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wp_q      <= '0;
      rp_q      <= '0;
      cnt_q     <= '0;
      rd_valid  <= 1'b0;
      not_empty <= 1'b0;
      overflow  <= 1'b0;
    end else begin
      if (do_wr) wp_q <= (wp_q == AW'(DEPTH - 1)) ? '0 : wp_q + 1'b1;
      if (do_rd) rp_q <= (rp_q == AW'(DEPTH - 1)) ? '0 : rp_q + 1'b1;
      cnt_q     <= cnt_d;
      not_empty <= (cnt_d != '0);
      rd_valid  <= do_rd;
      if (push && !do_wr) overflow <= 1'b1;
      else if (ovf_clr)   overflow <= 1'b0;
    end
  end
endmodule

// File: rtl/rxo_uart_rx.sv
module rxo_uart_rx
  import rxo_pkg::*;
#(
  parameter int MAX_BITS = 8,
  parameter int DIV_W    = 16,
  parameter int DEPTH    = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                rx_en,
  input  logic                rx_serial,
  input  logic [LEN_W-1:0]    cfg_len,
  input  logic                cfg_two_stop,
  input  logic [DIV_W-1:0]    samp_div,
  input  logic                pop,
  input  logic                ovf_clr,
  output logic [MAX_BITS-1:0] rd_data,
  output logic                rd_valid,
  output logic                not_empty,
  output logic                overflow
);
  logic [1:0]          sync_q;
  logic                tick;
  logic                smp_push;
  logic [MAX_BITS-1:0] smp_data;
  logic                fifo_full;

  always_ff @(posedge clk) begin
    if (rst) sync_q <= 2'b11;
    else     sync_q <= {sync_q[0], rx_serial};
  end

  rxo_tick_gen #(.DIV_W(DIV_W)) u_tick (
    .clk  (clk),
    .rst  (rst),
    .en   (rx_en),
    .div  (samp_div),
    .tick (tick)
  );

  rxo_word_sampler #(.MAX_BITS(MAX_BITS)) u_sampler (
    .clk          (clk),
    .rst          (rst),
    .en           (rx_en),
    .tick         (tick),
    .line_s       (sync_q[1]),
    .cfg_len      (cfg_len),
    .cfg_two_stop (cfg_two_stop),
    .push         (smp_push),
    .push_data    (smp_data)
  );

  rxo_fifo #(.DATA_W(MAX_BITS), .DEPTH(DEPTH)) u_fifo (
    .clk       (clk),
    .rst       (rst),
    .push      (smp_push),
    .wdata     (smp_data),
    .pop       (pop),
    .ovf_clr   (ovf_clr),
    .rd_data   (rd_data),
    .rd_valid  (rd_valid),
    .not_empty (not_empty),
    .overflow  (overflow),
    .full      (fifo_full)
  );
endmodule

// File: rtl/rxo_uart_rx_chk.sv
module rxo_uart_rx_chk (
  input logic clk,
  input logic rst,
  input logic rx_en,
  input logic pop,
  input logic ovf_clr,
  input logic rd_valid,
  input logic not_empty,
  input logic overflow,
  input logic push,
  input logic fifo_full
);
  p_reset_flags_r1: assert property (@(posedge clk)
    rst |=> (!not_empty && !overflow && !rd_valid));

  p_push_nempty_r7: assert property (@(posedge clk) disable iff (rst)
    push |=> not_empty);

  p_pop_valid_r7: assert property (@(posedge clk) disable iff (rst)
    (pop && not_empty) |=> rd_valid);

  p_pop_empty_r7: assert property (@(posedge clk) disable iff (rst)
    (pop && !not_empty) |=> !rd_valid);

  p_ovf_set_r8: assert property (@(posedge clk) disable iff (rst)
    (push && fifo_full && !pop) |=> overflow);

  p_ovf_hold_r9: assert property (@(posedge clk) disable iff (rst)
    (overflow && !ovf_clr) |=> overflow);

  p_ovf_clear_r9: assert property (@(posedge clk) disable iff (rst)
    (ovf_clr && !(push && fifo_full && !pop)) |=> !overflow);

  p_no_push_off_r10: assert property (@(posedge clk) disable iff (rst)
    !rx_en |=> !push);
endmodule

bind rxo_uart_rx rxo_uart_rx_chk u_chk (
  .clk       (clk),
  .rst       (rst),
  .rx_en     (rx_en),
  .pop       (pop),
  .ovf_clr   (ovf_clr),
  .rd_valid  (rd_valid),
  .not_empty (not_empty),
  .overflow  (overflow),
  .push      (smp_push),
  .fifo_full (fifo_full)
);

// File: tb/rxo_uart_rx_tb.sv
`timescale 1ns/1ps
module rxo_uart_rx_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        rx_en = 1'b0;
  logic        rx_serial = 1'b1;
  logic [1:0]  cfg_len = 2'd3;
  logic        cfg_two_stop = 1'b0;
  logic [15:0] samp_div = 16'd7;
  logic        pop = 1'b0;
  logic        ovf_clr = 1'b0;
  logic [7:0]  rd_data;
  logic        rd_valid, not_empty, overflow;

  int n_chk = 0;
  int n_bad = 0;
  int bit_t = 16;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  rxo_uart_rx u_dut (
    .clk(clk), .rst(rst), .rx_en(rx_en), .rx_serial(rx_serial),
    .cfg_len(cfg_len), .cfg_two_stop(cfg_two_stop), .samp_div(samp_div),
    .pop(pop), .ovf_clr(ovf_clr), .rd_data(rd_data), .rd_valid(rd_valid),
    .not_empty(not_empty), .overflow(overflow)
  );

  // {len code, two stop, data}
  localparam logic [10:0] VEC [8] = '{
    {2'd3, 1'b0, 8'hA5}, {2'd3, 1'b1, 8'h3C}, {2'd0, 1'b0, 8'hFF},
    {2'd1, 1'b1, 8'h2A}, {2'd2, 1'b0, 8'hD5}, {2'd0, 1'b1, 8'h13},
    {2'd3, 1'b0, 8'h55}, {2'd3, 1'b1, 8'h80}
  };

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send_char(input logic [7:0] d, input int nd, input int ns);
    rx_serial = 1'b0;
    wait_clk(bit_t);
    for (int k = 0; k < nd; k++) begin
      rx_serial = d[k];
      wait_clk(bit_t);
    end
    rx_serial = 1'b1;
    wait_clk((ns + 2) * bit_t);
  endtask

  task automatic pop_check(input logic [7:0] exp, input string tag);
    pop = 1'b1;
    @(negedge clk);
    pop = 1'b0;
    chk(rd_valid === 1'b1, {tag, " rd_valid"}, int'(rd_valid), 1);
    chk(rd_data === exp, {tag, " data"}, int'(rd_data), int'(exp));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    wait_clk(4);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk(not_empty === 1'b0, "R1 not_empty", int'(not_empty), 0);
    chk(overflow === 1'b0, "R1 overflow", int'(overflow), 0);
    chk(rd_valid === 1'b0, "R1 rd_valid", int'(rd_valid), 0);

    // R5: line low from the start never opens a word
    rx_serial = 1'b0;
    rx_en = 1'b1;
    wait_clk(10 * bit_t);
    rx_serial = 1'b1;
    wait_clk(3 * bit_t);
    chk(not_empty === 1'b0, "R5 low line ignored", int'(not_empty), 0);

    // R7 pop on empty
    pop = 1'b1; @(negedge clk); pop = 1'b0;
    chk(rd_valid === 1'b0, "R7 empty pop", int'(rd_valid), 0);

    // vector table: R2 R3 R4 R6 R7
    for (int i = 0; i < 8; i++) begin
      logic [7:0] exp;
      int nd;
      cfg_len = VEC[i][10:9];
      cfg_two_stop = VEC[i][8];
      nd = 5 + int'(VEC[i][10:9]);
      exp = VEC[i][7:0] & 8'((1 << nd) - 1);
      send_char(VEC[i][7:0], nd, 1 + int'(VEC[i][8]));
      chk(not_empty === 1'b1, "R7 not_empty after char", int'(not_empty), 1);
      pop_check(exp, "R2/R3/R4 vector");
      @(negedge clk);
      chk(not_empty === 1'b0, "R6 single entry per char", int'(not_empty), 0);
    end

    // R11: other divider setting
    cfg_len = 2'd3; cfg_two_stop = 1'b0;
    samp_div = 16'd3; bit_t = 8;
    wait_clk(4 * bit_t);
    send_char(8'hC9, 8, 1);
    pop_check(8'hC9, "R11 div=3");
    samp_div = 16'd7; bit_t = 16;
    wait_clk(4 * bit_t);

    // R10: disable mid-word keeps FIFO, drops partial word
    send_char(8'h5A, 8, 1);
    rx_serial = 1'b0; wait_clk(bit_t);
    for (int k = 0; k < 8; k++) begin
      if (k == 3) rx_en = 1'b0;
      rx_serial = k[0]; wait_clk(bit_t);
    end
    rx_serial = 1'b1;
    wait_clk(3 * bit_t);
    rx_en = 1'b1;
    wait_clk(4 * bit_t);
    chk(not_empty === 1'b1, "R10 fifo kept", int'(not_empty), 1);
    pop_check(8'h5A, "R10 stored char");
    @(negedge clk);
    chk(not_empty === 1'b0, "R10 partial dropped", int'(not_empty), 0);

    // R8 fill and overflow
    for (int i = 0; i < 8; i++) send_char(8'(i * 29 + 7), 8, 1);
    chk(overflow === 1'b0, "R8 eight fit", int'(overflow), 0);
    send_char(8'hEE, 8, 1);
    chk(overflow === 1'b1, "R8 overflow set", int'(overflow), 1);
    for (int i = 0; i < 8; i++) pop_check(8'(i * 29 + 7), "R8 order kept");
    @(negedge clk);
    chk(not_empty === 1'b0, "R8 ninth dropped", int'(not_empty), 0);

    // R9 sticky and clear
    wait_clk(20);
    chk(overflow === 1'b1, "R9 sticky", int'(overflow), 1);
    ovf_clr = 1'b1; @(negedge clk); ovf_clr = 1'b0;
    chk(overflow === 1'b0, "R9 cleared", int'(overflow), 0);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule